// File: doc/BRIEF.md
# I2C Master Clock-Phase Timing Generator

This block produces the line-drive enables an I2C master needs to issue a START condition, clock out a sequence of data bits, and close with a STOP condition. Two programmable counts set the timing, both in system clock cycles. The high count sets the START hold time, the SCL high time and the STOP setup time. The low count sets the SCL low time. Each phase adds its own fixed offset to its count, and each phase begins counting on its own event. The START hold and the SCL low phase are counted from the clock edge on which the block asserts its drive. The SCL high phase and the STOP setup are counted only once the synchronized SCL input reads high. A slow rise time or a slave that stretches the clock therefore lengthens the period instead of shortening the high time.

Both outputs are open-drain style drive-low enables: 1 pulls the line low and 0 releases it. The SCL input passes through a two-flop synchronizer before the block uses it. Higher-level logic supplies one data bit at a time. A one-cycle done pulse at the end of every high phase tells that logic to present the next bit, or to raise the stop request.

The controller has six states: IDLE, START_HOLD, BIT_LOW, BIT_HIGH, STOP_LOW and STOP_SETUP. The transitions are:
- launch: IDLE to START_HOLD.
- first fall: START_HOLD to BIT_LOW.
- release: BIT_LOW to BIT_HIGH.
- next bit: BIT_HIGH to BIT_LOW.
- close: BIT_HIGH to STOP_LOW.
- raise: STOP_LOW to STOP_SETUP.
- finish: STOP_SETUP to IDLE.

In the requirements below, H is the effective high count and L is the effective low count.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and in IDLE, both drive outputs are 0 and done is 0. A start request in IDLE drives SDA low (sda_drive_o=1) while SCL stays released. A start request in any other state has no effect on the sequence.
- R2: The START hold lasts exactly H+3 clock cycles, counted from the first cycle in which SDA is driven. At its end, SCL is driven low.
- R3: Each SCL low phase (scl_drive_o=1) lasts exactly L+1 cycles, whatever the SCL input does.
- R4: In BIT_HIGH, SCL is released. Counting waits for the synchronized SCL input to read high. Measured from the first cycle in which the SCL pin is high, the high phase lasts exactly H+8+2 cycles; the extra 2 are the synchronizer delay. A slave that holds SCL low extends the phase.
- R5: On the clock edge that enters each BIT_LOW, the block samples bit_i. It sets sda_drive_o to the inverse of that bit (bit 1 releases SDA, bit 0 drives it low). sda_drive_o then stays constant through that BIT_LOW and the BIT_HIGH that follows.
- R6: bit_done_o is high for exactly one cycle per high phase: the last cycle of BIT_HIGH.
- R7: stop_req_i is sampled only in the done cycle. If it is 1, the block enters STOP_LOW, in which both lines are driven low for L+1 cycles. If it is 0, the next BIT_LOW follows. A stop request raised at other times has no effect.
- R8: In STOP_SETUP, SCL is released and SDA is still driven. Once the synchronized SCL input reads high, the block counts H+3 cycles, then releases SDA and returns to IDLE. From the first high pin cycle, STOP_SETUP takes H+5 cycles.
- R9: H is the high count and L is the low count, except that a programmed count of 0 is used as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| high_cnt_i | input | CNT_W | High count (START hold, SCL high, STOP setup) |
| low_cnt_i | input | CNT_W | Low count (SCL low) |
| start_req_i | input | 1 | Begin a transfer with a START condition |
| stop_req_i | input | 1 | End with a STOP after the current bit |
| bit_i | input | 1 | Next data bit to place on SDA |
| scl_i | input | 1 | Raw SCL line level |
| scl_drive_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_o | output | 1 | 1 pulls SDA low, 0 releases it |
| bit_done_o | output | 1 | One-cycle pulse at the end of each high phase |

## Verification
The hardest situation to reach is a high phase whose counting is held back by a slave keeping SCL low. Only then does the synchronized-level condition, rather than the release edge, set the phase length. The bench models the SCL line as a wired AND of the block's drive and a slave hold signal. It asserts the hold during the low phase and keeps it for a random number of cycles into the high phase, with random counts including zero. It measures the high time from the first cycle the pin reads high. Directed transfers also pulse start and stop requests at moments when they must be ignored.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_HOLD,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_STOP_LOW,
        ST_STOP_SETUP
    } tg_state_e;

    localparam int HOLD_OFS  = 3;
    localparam int LOW_OFS   = 1;
    localparam int HIGH_OFS  = 8;
    localparam int SETUP_OFS = 3;
    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/scl_tg_sync.sv
module scl_tg_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[s] <= RESET_VAL;
                    else         chain_q[s] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[s] <= RESET_VAL;
                    else         chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scl_tg_counter.sv
module scl_tg_counter #(
    parameter int W = 20
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         en_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     cnt_q <= '0;
        else if (load_i)                 cnt_q <= load_val_i;
        else if (en_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scl_tg_fsm.sv
module scl_tg_fsm
    import scl_tg_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int W     = CNT_W + 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] high_cnt_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic             start_req_i,
    input  logic             stop_req_i,
    input  logic             bit_i,
    input  logic             scl_sense_i,
    input  logic             cnt_zero_i,
    output logic             cnt_load_o,
    output logic [W-1:0]     cnt_val_o,
    output logic             cnt_en_o,
    output logic             scl_drive_o,
    output logic             sda_drive_o,
    output logic             bit_done_o
);
    tg_state_e state_q, state_d;
    logic      armed_q;
    logic      sda_bit_q;
    logic      sda_load;
    logic      go;
    logic [W-1:0] h_eff, l_eff;

    // R9: zero counts are treated as one
    assign h_eff = (high_cnt_i == '0) ? W'(1) : W'(high_cnt_i);
    assign l_eff = (low_cnt_i  == '0) ? W'(1) : W'(low_cnt_i);

    // counting in the released phases only once SCL is sensed high (R4, R8)
    assign go = armed_q | scl_sense_i;

    always_comb begin
        state_d    = state_q;
        cnt_load_o = 1'b0;
        cnt_val_o  = '0;
        cnt_en_o   = 1'b0;
        sda_load   = 1'b0;
        bit_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req_i) begin
                    state_d    = ST_START_HOLD;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = h_eff + W'(HOLD_OFS - 1);
                end
            end
            ST_START_HOLD: begin
                cnt_en_o = 1'b1;
                if (cnt_zero_i) begin
                    state_d    = ST_BIT_LOW;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = l_eff + W'(LOW_OFS - 1);
                    sda_load   = 1'b1;
                end
            end
            ST_BIT_LOW: begin
                cnt_en_o = 1'b1;
                if (cnt_zero_i) begin
                    state_d    = ST_BIT_HIGH;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = h_eff + W'(HIGH_OFS - 1);
                end
            end
            ST_BIT_HIGH: begin
                if (go) begin
                    cnt_en_o = 1'b1;
                    if (cnt_zero_i) begin
                        bit_done_o = 1'b1;
                        cnt_load_o = 1'b1;
                        cnt_val_o  = l_eff + W'(LOW_OFS - 1);
                        if (stop_req_i) begin
                            state_d = ST_STOP_LOW;
                        end else begin
                            state_d  = ST_BIT_LOW;
                            sda_load = 1'b1;
                        end
                    end
                end
            end
            ST_STOP_LOW: begin
                cnt_en_o = 1'b1;
                if (cnt_zero_i) begin
                    state_d    = ST_STOP_SETUP;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = h_eff + W'(SETUP_OFS - 1);
                end
            end
            ST_STOP_SETUP: begin
                if (go) begin
                    cnt_en_o = 1'b1;
                    if (cnt_zero_i) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            armed_q   <= 1'b0;
            sda_bit_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cnt_load_o)
                armed_q <= 1'b0;
            else if ((state_q == ST_BIT_HIGH || state_q == ST_STOP_SETUP) && scl_sense_i)
                armed_q <= 1'b1;
            if (sda_load)
                sda_bit_q <= ~bit_i;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:       begin scl_drive_o = 1'b0; sda_drive_o = 1'b0;      end
            ST_START_HOLD: begin scl_drive_o = 1'b0; sda_drive_o = 1'b1;      end
            ST_BIT_LOW:    begin scl_drive_o = 1'b1; sda_drive_o = sda_bit_q; end
            ST_BIT_HIGH:   begin scl_drive_o = 1'b0; sda_drive_o = sda_bit_q; end
            ST_STOP_LOW:   begin scl_drive_o = 1'b1; sda_drive_o = 1'b1;      end
            ST_STOP_SETUP: begin scl_drive_o = 1'b0; sda_drive_o = 1'b1;      end
            default:       begin scl_drive_o = 1'b0; sda_drive_o = 1'b0;      end
        endcase
    end

    // R1: the START hold is entered only from IDLE
    a_r1_hold_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_START_HOLD && $past(state_q) != ST_START_HOLD) |-> $past(state_q) == ST_IDLE);

    // R3/R9: a low phase never lasts fewer than two cycles
    a_r3_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BIT_HIGH && $past(state_q) == ST_BIT_LOW) |-> $past(state_q, 2) == ST_BIT_LOW);

    // R4: while SCL is unsensed and not armed, the high phase cannot end
    a_r4_wait_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BIT_HIGH && !armed_q && !scl_sense_i) |=> state_q == ST_BIT_HIGH);

    // R5: SDA does not move while SCL is released within a bit
    a_r5_sda_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BIT_HIGH && $past(state_q) == ST_BIT_HIGH) |-> $stable(sda_drive_o));

    // R6: done lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_done_o |=> !bit_done_o);

    // R8: SDA is released only while SCL is sensed high
    a_r8_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_q) == ST_STOP_SETUP && state_q == ST_IDLE) |-> $past(go));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] high_cnt_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic             start_req_i,
    input  logic             stop_req_i,
    input  logic             bit_i,
    input  logic             scl_i,
    output logic             scl_drive_o,
    output logic             sda_drive_o,
    output logic             bit_done_o
);
    localparam int W = CNT_W + 4;

    logic         scl_sense;
    logic         cnt_load, cnt_en, cnt_zero;
    logic [W-1:0] cnt_val;

    scl_tg_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_scl_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (scl_i),
        .q_o    (scl_sense)
    );

    scl_tg_counter #(.W(W)) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .en_i       (cnt_en),
        .zero_o     (cnt_zero)
    );

    scl_tg_fsm #(.CNT_W(CNT_W), .W(W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .high_cnt_i  (high_cnt_i),
        .low_cnt_i   (low_cnt_i),
        .start_req_i (start_req_i),
        .stop_req_i  (stop_req_i),
        .bit_i       (bit_i),
        .scl_sense_i (scl_sense),
        .cnt_zero_i  (cnt_zero),
        .cnt_load_o  (cnt_load),
        .cnt_val_o   (cnt_val),
        .cnt_en_o    (cnt_en),
        .scl_drive_o (scl_drive_o),
        .sda_drive_o (sda_drive_o),
        .bit_done_o  (bit_done_o)
    );
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hcnt = 16'd4, lcnt = 16'd4;
    logic        start_req = 1'b0, stop_req = 1'b0, bit_in = 1'b0;
    logic        hold = 1'b0;
    logic        scl_drive, sda_drive, done;
    logic        scl_line;
    int          checks = 0, errors = 0;
    int          cyc = 0;
    bit          finished = 1'b0;

    assign scl_line = ~(scl_drive | hold);

    always #10 clk = ~clk;

    scl_timing_gen u_scl_timing_gen (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .high_cnt_i  (hcnt),
        .low_cnt_i   (lcnt),
        .start_req_i (start_req),
        .stop_req_i  (stop_req),
        .bit_i       (bit_in),
        .scl_i       (scl_line),
        .scl_drive_o (scl_drive),
        .sda_drive_o (sda_drive),
        .bit_done_o  (done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff(input logic [15:0] v);
        return (v == 16'd0) ? 1 : int'(v);
    endfunction

    task automatic run_txn(input logic [15:0] h, input logic [15:0] l, input int nbits,
                           input logic [7:0] data, input int stretch,
                           input bit poke_start, input bit poke_stop);
        int he, le, c, k, dn;
        bit last_done, exp_sda;
        he = eff(h);
        le = eff(l);
        @(negedge clk);
        hcnt = h; lcnt = l; bit_in = data[0];
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(sda_drive && !scl_drive, "R1 start drives SDA only", int'(sda_drive), 1);
        c = 0;
        while (sda_drive && !scl_drive) begin c++; @(negedge clk); end
        check(c == he + 3, "R2 START hold length", c, he + 3);
        // R9 covered when h or l is zero
        for (int i = 0; i < nbits; i++) begin
            exp_sda = ~data[i];
            c = 0;
            hold = (stretch > 0);
            if (poke_stop && i == 0) stop_req = 1'b1;
            while (scl_drive) begin
                c++;
                if (sda_drive != exp_sda)
                    check(1'b0, "R5 SDA in low phase", int'(sda_drive), int'(exp_sda));
                @(negedge clk);
            end
            check(c == le + 1, "R3 low phase length", c, le + 1);
            check(sda_drive == exp_sda, "R5 SDA data value", int'(sda_drive), int'(exp_sda));
            c = 0; k = 0; dn = 0; last_done = 1'b0;
            while (!scl_drive && sda_drive == exp_sda) begin
                if (k >= stretch && hold) begin hold = 1'b0; #1; end
                if (k == 0) stop_req = 1'b0;
                if (poke_start && k == 1) start_req = 1'b1;
                if (poke_start && k == 2) start_req = 1'b0;
                k++;
                if (scl_line) c++;
                last_done = done;
                if (done) begin
                    dn++;
                    if (i < nbits - 1) bit_in = data[i+1];
                    else               stop_req = 1'b1;
                end
                @(negedge clk);
            end
            check(c == he + 10, "R4 high phase from pin high", c, he + 10);
            check(dn == 1 && last_done, "R6 single done at phase end", dn, 1);
            check(scl_drive == 1'b1, "R7 low or stop follows high", int'(scl_drive), 1);
        end
        c = 0;
        while (scl_drive) begin
            stop_req = 1'b0;
            c++;
            if (!sda_drive) check(1'b0, "R7 SDA low in stop low", 0, 1);
            @(negedge clk);
        end
        check(c == le + 1, "R7 stop low length", c, le + 1);
        c = 0;
        while (sda_drive && !scl_drive) begin c++; @(negedge clk); end
        check(c == he + 5, "R8 stop setup length", c, he + 5);
        check(!sda_drive && !scl_drive, "R8 lines released", int'(sda_drive | scl_drive), 0);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check(!sda_drive && !scl_drive && !done, "R1 stays idle", int'(sda_drive), 0);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check(!sda_drive && !scl_drive && !done, "R1 reset state", int'(sda_drive | scl_drive | done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sda_drive && !scl_drive, "R1 idle after reset", int'(sda_drive | scl_drive), 0);
        // directed corners
        run_txn(16'd0, 16'd0, 2, 8'b10, 0, 1'b0, 1'b0);     // R9 both clamped
        run_txn(16'd5, 16'd3, 3, 8'b101, 4, 1'b0, 1'b0);    // R4 stretched high
        run_txn(16'd2, 16'd6, 2, 8'b01, 0, 1'b1, 1'b1);     // R1 start ignored, R7 early stop ignored
        run_txn(16'd1, 16'd1, 1, 8'b1, 9, 1'b0, 1'b0);      // R4 long stretch
        // random transfers
        for (int t = 0; t < 25; t++) begin
            run_txn(16'($urandom_range(0, 20)), 16'($urandom_range(0, 20)),
                    int'($urandom_range(1, 5)), 8'($urandom), int'($urandom_range(0, 6)),
                    1'($urandom), 1'($urandom));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule